// File: doc/BRIEF.md
# Configurable Logic Cell with Edge Delay Filters

This block is a single programmable logic cell. Four selector stages each choose one bit from a pool of sources. The pool holds a constant zero, a bank of external inputs, and the outputs of neighbouring cells, so cells can feed one another. The four chosen bits form an index into a 16-bit truth table. The bit read from the table can be inverted, and then passes through a delay filter. The filter holds a rising transition back by one programmable count and a falling transition by another. If the function drops back before the count runs out, the pending change is cancelled. A typical use is to shape edge pulses, or to decode two phase signals into direction pulses by combining a signal with a delayed copy of itself.

Software sets up the cell through a plain write port. Each selector stage has its own word: a source code, plus an override that forces that stage to a chosen value. There are also words for the truth table, for the two delay counts, and for control. The control word holds an inversion flag and an output enable. The cell drives its output only while the enable is set.

Top module: `logic_cell`

## Requirements
- R1: After reset the output is 0 and every setting is cleared: all source codes 0, overrides off, truth table 0, both delay counts 0, inversion off and output enable off. Register writes take effect from the second clock after reset is released.
- R2: Each selector stage decodes its 5-bit source code as follows. Code 0 gives constant 0. Codes 1 to 12 give external input (code-1). Codes 13 to 24 give neighbour output (code-13). Codes 25 to 31 give 0.
- R3: The function value is bit `idx` of the truth table, where `idx` bit k is the output of selector stage k (stage 0 is the LSB). Register writes use these addresses. Address k (0 to 3) configures stage k: bits [4:0] are the source code, bit 8 enables the override and bit 9 is the override value. Address 4 holds the truth table in bits [15:0]. Address 5 holds the rise count in bits [7:0] and the fall count in bits [15:8]. Address 6 holds inversion in bit 0 and output enable in bit 1. A write to address 7 has no effect.
- R4: Suppose the function goes from 0 to 1 and stays 1, and the rise count is R. The filtered state then becomes 1 at the (R+1)th rising clock edge after the first edge at which the function is 1. With R = 0 this is one register of latency.
- R5: A falling transition behaves the same way, using the fall count F.
- R6: If the function returns to the current filtered state before the count has expired, no transition occurs. The count then restarts from zero at the next difference.
- R7: While a stage's override is enabled, that stage outputs the override value in place of its selected source. This applies from the clock edge that writes the setting.
- R8: When inversion is set, the function value is inverted before it enters the delay filter.
- R9: The output is 0 while output enable is clear. While enable is set, the output equals the filtered state. Enable acts from the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | NUM_EXT | External source bits |
| peer_in | input | NUM_PEER | Outputs of neighbouring cells |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| cell_out | output | 1 | Filtered, enabled cell output |

## Verification
Two events can land on the same clock edge. One is a delay count expiring. The other is the function returning to the old level, either because a source changed or because a register write altered a table, override or count. The rule is that a return on the expiry edge cancels the transition, and a count lowered below the elapsed count fires at once. Small random delay counts, together with random source changes and random register writes, provoke these coincidences often. A cycle-level bench model built from the requirements judges every cycle. Directed tests measure the exact rise and fall latency, and test a pulse that is one cycle too short to pass.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_NUM_SEL = 4;
  localparam int LC_LUT_W   = 1 << LC_NUM_SEL;
  localparam int LC_ADDR_W  = 3;
  localparam int LC_DATA_W  = 16;

  typedef enum logic [LC_ADDR_W-1:0] {
    ADR_IN0  = 3'd0,
    ADR_IN1  = 3'd1,
    ADR_IN2  = 3'd2,
    ADR_IN3  = 3'd3,
    ADR_LUT  = 3'd4,
    ADR_FILT = 3'd5,
    ADR_CTRL = 3'd6,
    ADR_NONE = 3'd7
  } lc_addr_e;

  localparam int LC_OVR_EN_BIT  = 8;
  localparam int LC_OVR_VAL_BIT = 9;
  localparam int LC_FALL_LSB    = 8;
  localparam int LC_INV_BIT     = 0;
  localparam int LC_EN_BIT      = 1;
endpackage

// File: rtl/lc_cfg_regs.sv
module lc_cfg_regs
  import lc_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int CNT_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [LC_ADDR_W-1:0]              addr_i,
  input  logic [LC_DATA_W-1:0]              wdata_i,
  output logic [LC_NUM_SEL-1:0][SEL_W-1:0]  code_o,
  output logic [LC_NUM_SEL-1:0]             ovr_en_o,
  output logic [LC_NUM_SEL-1:0]             ovr_val_o,
  output logic [LC_LUT_W-1:0]               lut_o,
  output logic [CNT_W-1:0]                  rise_o,
  output logic [CNT_W-1:0]                  fall_o,
  output logic                              inv_o,
  output logic                              en_o
);
  logic [LC_NUM_SEL-1:0][SEL_W-1:0] code_q, code_d;
  logic [LC_NUM_SEL-1:0]            oen_q, oen_d, oval_q, oval_d;
  logic [LC_LUT_W-1:0]              lut_q, lut_d;
  logic [CNT_W-1:0]                 rise_q, rise_d, fall_q, fall_d;
  logic                             inv_q, inv_d, en_q, en_d;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata_i;

  always_comb begin
    code_d = code_q;
    oen_d  = oen_q;
    oval_d = oval_q;
    lut_d  = lut_q;
    rise_d = rise_q;
    fall_d = fall_q;
    inv_d  = inv_q;
    en_d   = en_q;
    if (we_i) begin
      for (int k = 0; k < LC_NUM_SEL; k++) begin
        if (addr_i == LC_ADDR_W'(k)) begin
          code_d[k] = wdata_i[SEL_W-1:0];
          oen_d[k]  = wdata_i[LC_OVR_EN_BIT];
          oval_d[k] = wdata_i[LC_OVR_VAL_BIT];
        end
      end
      case (addr_i)
        ADR_LUT:  lut_d = wdata_i[LC_LUT_W-1:0];
        ADR_FILT: begin
          rise_d = wdata_i[CNT_W-1:0];
          fall_d = wdata_i[LC_FALL_LSB +: CNT_W];
        end
        ADR_CTRL: begin
          inv_d = wdata_i[LC_INV_BIT];
          en_d  = wdata_i[LC_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      oen_q  <= '0;
      oval_q <= '0;
      lut_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      inv_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      code_q <= code_d;
      oen_q  <= oen_d;
      oval_q <= oval_d;
      lut_q  <= lut_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      inv_q  <= inv_d;
      en_q   <= en_d;
    end
  end

  assign code_o    = code_q;
  assign ovr_en_o  = oen_q;
  assign ovr_val_o = oval_q;
  assign lut_o     = lut_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign inv_o     = inv_q;
  assign en_o      = en_q;

  // R3: a table write is visible on the next cycle
  p_lut_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADR_LUT) |=> (lut_o == $past(wdata_i[LC_LUT_W-1:0])));

  // R3: address 7 leaves the control settings alone
  p_null_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADR_NONE) |=> ($stable(en_o) && $stable(inv_o) && $stable(lut_o)));
endmodule

// File: rtl/lc_src_mux.sv
module lc_src_mux #(
  parameter int NUM_EXT  = 12,
  parameter int NUM_PEER = 12,
  parameter int SEL_W    = 5
) (
  input  logic [SEL_W-1:0]    code_i,
  input  logic                ovr_en_i,
  input  logic                ovr_val_i,
  input  logic [NUM_EXT-1:0]  ext_i,
  input  logic [NUM_PEER-1:0] peer_i,
  output logic                bit_o
);
  logic pick;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (code_i == SEL_W'(i + 1)) pick = ext_i[i];
    end
    for (int j = 0; j < NUM_PEER; j++) begin
      if (code_i == SEL_W'(NUM_EXT + 1 + j)) pick = peer_i[j];
    end
  end

  assign bit_o = ovr_en_i ? ovr_val_i : pick;
endmodule

// File: rtl/lc_edge_filter.sv
module lc_edge_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_i,
  input  logic [CNT_W-1:0] rise_lim_i,
  input  logic [CNT_W-1:0] fall_lim_i,
  output logic             state_o
);
  logic             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;
  logic             differ, expired;

  assign lim     = func_i ? rise_lim_i : fall_lim_i;
  assign differ  = (func_i != state_q);
  assign expired = (cnt_q >= lim);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (expired) begin
      state_d = func_i;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R6: no difference means no transition
  p_hold_when_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i == state_q) |=> $stable(state_q));

  // R4: a rise count of zero gives a single register of latency
  p_zero_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (func_i && !state_q && rise_lim_i == '0) |=> state_q);

  // R5: no transition while the count has not expired
  p_early_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (differ && cnt_q < lim) |=> $stable(state_q));
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lc_pkg::*;
#(
  parameter int NUM_EXT  = 12,
  parameter int NUM_PEER = 12,
  parameter int CNT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EXT-1:0]   ext_in,
  input  logic [NUM_PEER-1:0]  peer_in,
  input  logic                 cfg_we,
  input  logic [LC_ADDR_W-1:0] cfg_addr,
  input  logic [LC_DATA_W-1:0] cfg_wdata,
  output logic                 cell_out
);
  localparam int SEL_W = $clog2(NUM_EXT + NUM_PEER + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LC_NUM_SEL-1:0][SEL_W-1:0] code;
  logic [LC_NUM_SEL-1:0]            ovr_en, ovr_val, sel_bits;
  logic [LC_LUT_W-1:0]              lut;
  logic [CNT_W-1:0]                 rise_lim, fall_lim;
  logic                             inv, en, func, filt_state;

  lc_cfg_regs #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n),
    .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .code_o(code), .ovr_en_o(ovr_en), .ovr_val_o(ovr_val),
    .lut_o(lut), .rise_o(rise_lim), .fall_o(fall_lim),
    .inv_o(inv), .en_o(en)
  );

  for (genvar k = 0; k < LC_NUM_SEL; k++) begin : g_sel
    lc_src_mux #(.NUM_EXT(NUM_EXT), .NUM_PEER(NUM_PEER), .SEL_W(SEL_W)) u_mux (
      .code_i(code[k]), .ovr_en_i(ovr_en[k]), .ovr_val_i(ovr_val[k]),
      .ext_i(ext_in), .peer_i(peer_in), .bit_o(sel_bits[k])
    );

    // R7: an enabled override drives the stage
    p_override_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
      ovr_en[k] |-> (sel_bits[k] == ovr_val[k]));

    // R2: code zero without override yields 0
    p_zero_code_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!ovr_en[k] && code[k] == '0) |-> !sel_bits[k]);
  end

  assign func = lut[sel_bits] ^ inv;

  lc_edge_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .func_i(func),
    .rise_lim_i(rise_lim), .fall_lim_i(fall_lim), .state_o(filt_state)
  );

  assign cell_out = filt_state & en;

  // R9: while disabled the output never rises
  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en && !$past(cfg_we)) |-> !cell_out);
endmodule

// File: tb/logic_cell_test.sv
module logic_cell_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ext_in;
  logic [11:0] peer_in;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        cell_out;

  int checks = 0;
  int fails  = 0;
  bit model_chk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_cell uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .peer_in(peer_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cell_out(cell_out)
  );

  // bench model state, built from the requirements
  logic [4:0]  m_code [4];
  logic        m_oen  [4];
  logic        m_oval [4];
  logic [15:0] m_lut;
  logic [7:0]  m_rise, m_fall, m_cnt;
  logic        m_inv, m_en, m_state;

  function automatic logic pick(input logic [4:0] c, input logic oe, input logic ov);
    if (oe) return ov;
    if (c == 0) return 1'b0;
    if (c <= 12) return ext_in[c-1];
    if (c <= 24) return peer_in[c-13];
    return 1'b0;
  endfunction

  function automatic logic mfunc();
    logic [3:0] ix;
    for (int k = 0; k < 4; k++) ix[k] = pick(m_code[k], m_oen[k], m_oval[k]);
    return m_lut[ix] ^ m_inv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_code[k] = '0; m_oen[k] = 1'b0; m_oval[k] = 1'b0;
      end
      m_lut = '0; m_rise = '0; m_fall = '0; m_cnt = '0;
      m_inv = 1'b0; m_en = 1'b0; m_state = 1'b0;
    end else begin
      logic f;
      logic [7:0] lim;
      f = mfunc();
      lim = f ? m_rise : m_fall;
      if (f == m_state) m_cnt = '0;
      else if (m_cnt >= lim) begin m_state = f; m_cnt = '0; end
      else m_cnt = m_cnt + 1;
      if (cfg_we) begin
        if (cfg_addr < 4) begin
          m_code[cfg_addr] = cfg_wdata[4:0];
          m_oen[cfg_addr]  = cfg_wdata[8];
          m_oval[cfg_addr] = cfg_wdata[9];
        end else if (cfg_addr == 4) m_lut = cfg_wdata;
        else if (cfg_addr == 5) begin m_rise = cfg_wdata[7:0]; m_fall = cfg_wdata[15:8]; end
        else if (cfg_addr == 6) begin m_inv = cfg_wdata[0]; m_en = cfg_wdata[1]; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_chk) chk(cell_out == (m_state & m_en), "R3 R4 R5 model", cell_out, m_state & m_en);
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (cell_out != lvl && n < 40) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int seed_dummy;
    seed_dummy = $urandom(32'h1234);
    rst_n = 1'b0; ext_in = '0; peer_in = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    chk(cell_out == 1'b0, "R1 reset output", cell_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_chk = 1'b1;

    // R1: cleared settings: only enabling gives 0 (table 0)
    wr(3'd6, 16'h0002);
    @(negedge clk);
    chk(cell_out == 1'b0, "R1 cleared table", cell_out, 0);
    wr(3'd4, 16'hFFFF);
    @(negedge clk);
    chk(cell_out == 1'b1, "R1 zero delay after reset", cell_out, 1);

    // R2: every source code; table passes stage 0
    wr(3'd4, 16'hAAAA);
    for (int c = 0; c < 32; c++) begin
      logic e;
      ext_in  = 12'($urandom);
      peer_in = 12'($urandom);
      wr(3'd0, 16'(c));
      @(negedge clk);
      if (c == 0 || c > 24) e = 1'b0;
      else if (c <= 12) e = ext_in[c-1];
      else e = peer_in[c-13];
      chk(cell_out == e, $sformatf("R2 code %0d", c), cell_out, e);
    end

    // R3: stages on ext 0..3, random table, all indices
    begin
      logic [15:0] tbl;
      tbl = 16'($urandom);
      wr(3'd0, 16'd1); wr(3'd1, 16'd2); wr(3'd2, 16'd3); wr(3'd3, 16'd4);
      wr(3'd4, tbl);
      wr(3'd7, 16'hFFFF);
      for (int i = 0; i < 16; i++) begin
        ext_in[3:0] = 4'(i);
        @(negedge clk);
        chk(cell_out == tbl[i], $sformatf("R3 index %0d", i), cell_out, tbl[i]);
      end
    end

    // R4 / R5: exact delays, stage 0 alone drives the function
    wr(3'd1, 16'd0); wr(3'd2, 16'd0); wr(3'd3, 16'd0);
    wr(3'd4, 16'hAAAA);
    ext_in = '0;
    wr(3'd5, 16'h0503);
    repeat (8) @(negedge clk);
    chk(cell_out == 1'b0, "R5 settled low", cell_out, 0);
    ext_in[0] = 1'b1;
    measure(1'b1, n);
    chk(n == 4, "R4 rise count 3", n, 4);
    ext_in[0] = 1'b0;
    measure(1'b0, n);
    chk(n == 6, "R5 fall count 5", n, 6);

    // R6: a pulse one cycle too short is swallowed, then the count restarts
    ext_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    ext_in[0] = 1'b0;
    repeat (8) @(negedge clk);
    chk(cell_out == 1'b0, "R6 short pulse cancelled", cell_out, 0);
    ext_in[0] = 1'b1;
    measure(1'b1, n);
    chk(n == 4, "R6 count restarted", n, 4);

    // R7: override on stage 0
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0100 | 16'd1);
    @(negedge clk);
    chk(cell_out == 1'b0, "R7 override low", cell_out, 0);
    wr(3'd0, 16'h0300);
    @(negedge clk);
    chk(cell_out == 1'b1, "R7 override high", cell_out, 1);
    ext_in[0] = 1'b0;
    wr(3'd0, 16'd1);
    @(negedge clk);
    chk(cell_out == 1'b0, "R7 override released", cell_out, 0);

    // R8: inversion
    wr(3'd6, 16'h0003);
    @(negedge clk);
    chk(cell_out == 1'b1, "R8 inverted", cell_out, 1);

    // R9: enable gating acts from the write edge
    wr(3'd6, 16'h0001);
    chk(cell_out == 1'b0, "R9 disabled", cell_out, 0);
    wr(3'd6, 16'h0003);
    chk(cell_out == 1'b1, "R9 re-enabled", cell_out, 1);

    // random phase with small delay counts
    wr(3'd5, 16'h0102);
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (($urandom % 3) == 0) begin
        ext_in  = 12'($urandom);
        peer_in = 12'($urandom);
      end
      if (($urandom % 12) == 0) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom);
        d = 16'($urandom);
        if (a < 4) d = (d & 16'h0300) | 16'($urandom % 32);
        else if (a == 5) d = {6'd0, 2'($urandom), 6'd0, 2'($urandom)};
        else if (a == 6) d = {14'd0, 1'b1, d[0]};
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    model_chk = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule